// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block sits on the reader side of a contact smart card interface. It drives the card's supply enable, clock enable, reset line and I/O receive enable through four phases. Power-up brings the contacts alive in a fixed order. Reset holds the card's reset line low for a set number of card-clock cycles and then releases it. The answer window then waits for the card's first answer character. Power-down removes the contacts in the opposite order. Every delay is counted in card-clock cycles.

A host asks for a session with a start request while a card is present. A character receiver reports the first falling start edge of the card's answer on `atrStart`. The sequencer judges whether that edge arrived inside the allowed window. An answer that comes too early or never comes is treated as a failed reset. The first such failure in a session triggers one automatic warm reset. A second failure marks the card as mute and powers it down. While the session is up, the host may request a warm reset or an end of session. Pulling the card out at any powered stage forces power-down on the next clock edge.

Top module: `card_session_seq`

## Requirements
- R1: After reset, every output is low: supply off, clock off, reset line low, I/O receive off, answer window closed, mute flag clear and ready clear.
- R2: A start request sampled while a card is present turns the supply on at the next clock edge. I/O receive comes on STEP_GAP_CYC cycles after that, and the clock STEP_GAP_CYC cycles after I/O. A start request without a card present has no effect.
- R3: Once the clock is running, the reset line stays low for exactly RST_HOLD_CYC cycles and is then driven high. The answer window output is high from that edge until the answer is judged.
- R4: Counting 0 for the first cycle the reset line is high, an answer start sampled at a count from ATR_MIN_CYC to ATR_MAX_CYC-1 inclusive raises ready at that edge and closes the window.
- R5: An answer start sampled at a count below ATR_MIN_CYC is a failed reset.
- R6: If no answer start has been sampled by count ATR_MAX_CYC-1, the reset fails at that edge, which comes ATR_MAX_CYC cycles after the reset line rises.
- R7: The first failed reset of a session drives the reset line low at the failing edge while supply and clock stay on, and mute stays clear. The reset line is then held low again for RST_HOLD_CYC cycles.
- R8: A failed reset after the automatic retry sets the mute flag and starts power-down at that same edge. The mute flag clears at the next accepted start request.
- R9: A warm reset request while ready drives the reset line low and clears ready at the next edge, leaving supply and clock on. After that the hold and answer window repeat as in R3 and R4.
- R10: An end request in any powered state drives the reset line low at the next edge. The clock goes off STEP_GAP_CYC cycles later, I/O receive STEP_GAP_CYC cycles after that, and the supply STEP_GAP_CYC cycles after that.
- R11: Removal of the card in any powered state starts the power-down of R10 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardPresent | input | 1 | Card seated in the socket |
| startReq | input | 1 | Request to begin a session |
| warmReq | input | 1 | Request a warm reset while ready |
| endReq | input | 1 | Request to end the session |
| atrStart | input | 1 | Start edge of the card's first answer character |
| vccEn | output | 1 | Card supply enable |
| clkEn | output | 1 | Card clock enable |
| cardRst | output | 1 | Level on the card reset contact |
| ioRxEn | output | 1 | I/O driver set to receive |
| atrWindow | output | 1 | Waiting for the card's answer |
| cardMute | output | 1 | Card failed to answer after the retry |
| ready | output | 1 | Card answered; session up |

## Verification
All outputs are registered, so every output change appears at the clock edge that samples its cause. It is therefore visible at the falling edge right after that. From the falling edge where one step is first seen, the bench counts falling edges until the next contact changes. It expects exactly STEP_GAP_CYC for each power-up and power-down step, RST_HOLD_CYC for the reset hold, and ATR_MAX_CYC for a timeout. Answer starts are driven after a counted number of falling edges from the first cycle the reset line is high, so the count at which they are sampled is known exactly. This sampling count sets the ATR_MIN_CYC-1, ATR_MIN_CYC and ATR_MAX_CYC-1 boundary cases.

// File: rtl/card_session_pkg.sv
package card_session_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWR,
    ST_IORX,
    ST_HOLD,
    ST_ATRW,
    ST_ACTIVE,
    ST_DRST,
    ST_DCLK,
    ST_DIO
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic vccOn;
    logic vccOff;
    logic ioOn;
    logic ioOff;
    logic clkOn;
    logic clkOff;
    logic rstHi;
    logic rstLo;
  } pinStrobe_t;

  // counter compare results back to control
  typedef struct packed {
    logic gapDone;
    logic holdDone;
    logic atrEarly;
    logic atrLast;
  } cntFlags_t;

endpackage

// File: rtl/card_session_dp.sv
module card_session_dp
  import card_session_pkg::*;
#(
  parameter int RST_HOLD_CYC = 40000,
  parameter int ATR_MIN_CYC  = 400,
  parameter int ATR_MAX_CYC  = 40000,
  parameter int STEP_GAP_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  pinStrobe_t stb,
  output cntFlags_t  flg,
  output logic       vccEn,
  output logic       ioRxEn,
  output logic       clkEn,
  output logic       rstLevel
);

  localparam int NPIN    = 4;
  localparam int TOP_A   = (RST_HOLD_CYC > ATR_MAX_CYC) ? RST_HOLD_CYC : ATR_MAX_CYC;
  localparam int CNT_TOP = (TOP_A > STEP_GAP_CYC) ? TOP_A : STEP_GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(STEP_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] ATR_LO    = CNT_W'(ATR_MIN_CYC);
  localparam logic [CNT_W-1:0] ATR_LAST  = CNT_W'(ATR_MAX_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAT   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [NPIN-1:0]  pinSet, pinClr, pinQ;

  // cycle counter, cleared on every state change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (stb.cntClr)     cnt <= '0;
    else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

  assign flg.gapDone  = (cnt == GAP_LAST);
  assign flg.holdDone = (cnt == HOLD_LAST);
  assign flg.atrEarly = (cnt < ATR_LO);
  assign flg.atrLast  = (cnt == ATR_LAST);

  // contact registers: index 0 supply, 1 io, 2 clock, 3 reset
  assign pinSet = {stb.rstHi, stb.clkOn,  stb.ioOn,  stb.vccOn};
  assign pinClr = {stb.rstLo, stb.clkOff, stb.ioOff, stb.vccOff};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ <= '0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (pinClr[i])      pinQ[i] <= 1'b0;
        else if (pinSet[i]) pinQ[i] <= 1'b1;
      end
    end
  end

  assign vccEn    = pinQ[0];
  assign ioRxEn   = pinQ[1];
  assign clkEn    = pinQ[2];
  assign rstLevel = pinQ[3];

  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> (ioRxEn && vccEn)); // R2

  AST_RST_HI_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    rstLevel |-> clkEn); // R3

  AST_VCC_DROPS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vccEn) |-> (!clkEn && !ioRxEn && !rstLevel)); // R10

  AST_CLK_OFF_AFTER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn) |-> !rstLevel); // R10

endmodule

// File: rtl/card_session_ctrl.sv
module card_session_ctrl
  import card_session_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cardPresent,
  input  logic       startReq,
  input  logic       warmReq,
  input  logic       endReq,
  input  logic       atrStart,
  input  cntFlags_t  flg,
  output pinStrobe_t stb,
  output logic       atrWindow,
  output logic       cardMute,
  output logic       ready
);

  seqState_t state, stateNxt;
  logic      retryUsed, retryNxt;
  logic      muteNxt;
  logic      powered;

  assign powered = state inside {ST_PWR, ST_IORX, ST_HOLD, ST_ATRW, ST_ACTIVE};

  always_comb begin
    stateNxt = state;
    retryNxt = retryUsed;
    muteNxt  = cardMute;
    stb      = '0;
    if (powered && (!cardPresent || endReq)) begin
      stateNxt  = ST_DRST;
      stb.rstLo = 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (cardPresent && startReq) begin
          stateNxt  = ST_PWR;
          stb.vccOn = 1'b1;
          retryNxt  = 1'b0;
          muteNxt   = 1'b0;
        end
        ST_PWR: if (flg.gapDone) begin
          stateNxt = ST_IORX;
          stb.ioOn = 1'b1;
        end
        ST_IORX: if (flg.gapDone) begin
          stateNxt  = ST_HOLD;
          stb.clkOn = 1'b1;
        end
        ST_HOLD: if (flg.holdDone) begin
          stateNxt  = ST_ATRW;
          stb.rstHi = 1'b1;
        end
        ST_ATRW: begin
          if (atrStart && !flg.atrEarly) begin
            stateNxt = ST_ACTIVE;
          end else if (atrStart || flg.atrLast) begin
            stb.rstLo = 1'b1;
            if (!retryUsed) begin
              stateNxt = ST_HOLD;
              retryNxt = 1'b1;
            end else begin
              stateNxt = ST_DRST;
              muteNxt  = 1'b1;
            end
          end
        end
        ST_ACTIVE: if (warmReq) begin
          stateNxt  = ST_HOLD;
          stb.rstLo = 1'b1;
        end
        ST_DRST: if (flg.gapDone) begin
          stateNxt   = ST_DCLK;
          stb.clkOff = 1'b1;
        end
        ST_DCLK: if (flg.gapDone) begin
          stateNxt  = ST_DIO;
          stb.ioOff = 1'b1;
        end
        ST_DIO: if (flg.gapDone) begin
          stateNxt   = ST_IDLE;
          stb.vccOff = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
    stb.cntClr = (stateNxt != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      retryUsed <= 1'b0;
      cardMute  <= 1'b0;
    end else begin
      state     <= stateNxt;
      retryUsed <= retryNxt;
      cardMute  <= muteNxt;
    end
  end

  assign atrWindow = (state == ST_ATRW);
  assign ready     = (state == ST_ACTIVE);

  AST_REMOVE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (powered && !cardPresent) |=> (state == ST_DRST)); // R11

  AST_MUTE_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardMute) |-> $past(retryUsed)); // R8

  AST_MUTE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    cardMute |-> !ready); // R8

endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
  import card_session_pkg::*;
#(
  parameter int RST_HOLD_CYC = 40000,
  parameter int ATR_MIN_CYC  = 400,
  parameter int ATR_MAX_CYC  = 40000,
  parameter int STEP_GAP_CYC = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic cardPresent,
  input  logic startReq,
  input  logic warmReq,
  input  logic endReq,
  input  logic atrStart,
  output logic vccEn,
  output logic clkEn,
  output logic cardRst,
  output logic ioRxEn,
  output logic atrWindow,
  output logic cardMute,
  output logic ready
);

  pinStrobe_t stb;
  cntFlags_t  flg;

  card_session_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cardPresent (cardPresent),
    .startReq    (startReq),
    .warmReq     (warmReq),
    .endReq      (endReq),
    .atrStart    (atrStart),
    .flg         (flg),
    .stb         (stb),
    .atrWindow   (atrWindow),
    .cardMute    (cardMute),
    .ready       (ready)
  );

  card_session_dp #(
    .RST_HOLD_CYC (RST_HOLD_CYC),
    .ATR_MIN_CYC  (ATR_MIN_CYC),
    .ATR_MAX_CYC  (ATR_MAX_CYC),
    .STEP_GAP_CYC (STEP_GAP_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .flg      (flg),
    .vccEn    (vccEn),
    .ioRxEn   (ioRxEn),
    .clkEn    (clkEn),
    .rstLevel (cardRst)
  );

  AST_READY_PINS: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cardRst && clkEn && vccEn && ioRxEn)); // R4

  AST_WINDOW_RST_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    atrWindow |-> cardRst); // R3

endmodule

// File: tb/card_session_seq_tb.sv
module card_session_seq_tb;

  localparam int GAP  = 2;
  localparam int HOLD = 20;
  localparam int AMIN = 5;
  localparam int AMAX = 30;

  localparam int P_VCC = 0, P_CLK = 1, P_RST = 2, P_IO = 3, P_WIN = 4, P_MUTE = 5, P_RDY = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cardPresent = 1'b0, startReq = 1'b0, warmReq = 1'b0, endReq = 1'b0, atrStart = 1'b0;
  logic vccEn, clkEn, cardRst, ioRxEn, atrWindow, cardMute, ready;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  card_session_seq #(
    .RST_HOLD_CYC (HOLD),
    .ATR_MIN_CYC  (AMIN),
    .ATR_MAX_CYC  (AMAX),
    .STEP_GAP_CYC (GAP)
  ) u_dut (
    .clk (clk), .rstN (rstN), .cardPresent (cardPresent), .startReq (startReq),
    .warmReq (warmReq), .endReq (endReq), .atrStart (atrStart),
    .vccEn (vccEn), .clkEn (clkEn), .cardRst (cardRst), .ioRxEn (ioRxEn),
    .atrWindow (atrWindow), .cardMute (cardMute), .ready (ready)
  );

  function automatic logic pinVal(int sel);
    case (sel)
      P_VCC:   return vccEn;
      P_CLK:   return clkEn;
      P_RST:   return cardRst;
      P_IO:    return ioRxEn;
      P_WIN:   return atrWindow;
      P_MUTE:  return cardMute;
      default: return ready;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkPin(string req, string what, int sel, int exp);
    chk(req, what, (pinVal(sel) === 1'b1) ? 1 : 0, exp);
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic waitFor(int sel, logic val, int lim, output int n);
    n = 0;
    while (pinVal(sel) !== val && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  // power-up, checking spacing; returns at first cycle with reset line high
  task automatic activate();
    int n;
    cardPresent = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chkPin("R2", "supply one cycle after start", P_VCC, 1);
    chkPin("R2", "io still off", P_IO, 0);
    chkPin("R8", "mute cleared by start", P_MUTE, 0);
    waitFor(P_IO, 1'b1, 100, n);
    chk("R2", "io delay after supply", n, GAP);
    chkPin("R2", "clock still off", P_CLK, 0);
    waitFor(P_CLK, 1'b1, 100, n);
    chk("R2", "clock delay after io", n, GAP);
    waitFor(P_RST, 1'b1, 200, n);
    chk("R3", "reset hold length", n, HOLD);
    chkPin("R3", "answer window open", P_WIN, 1);
  endtask

  task automatic sendAtr(int k);
    step(k);
    atrStart = 1'b1;
    @(negedge clk);
    atrStart = 1'b0;
  endtask

  task automatic deactCheck(string req);
    int n;
    waitFor(P_CLK, 1'b0, 100, n);
    chk(req, "clock off delay", n, GAP);
    chkPin(req, "io on while clock off", P_IO, 1);
    waitFor(P_IO, 1'b0, 100, n);
    chk(req, "io off delay", n, GAP);
    chkPin(req, "supply on while io off", P_VCC, 1);
    waitFor(P_VCC, 1'b0, 100, n);
    chk(req, "supply off delay", n, GAP);
    chkPin(req, "ready low after power-down", P_RDY, 0);
  endtask

  task automatic tReset();
    for (int s = 0; s <= P_RDY; s++) chkPin("R1", "output low after reset", s, 0);
  endtask

  task automatic tNoCard();
    cardPresent = 1'b0;
    startReq = 1'b1;
    step(4);
    startReq = 1'b0;
    step(1);
    chkPin("R2", "no supply without card", P_VCC, 0);
    chkPin("R2", "no clock without card", P_CLK, 0);
  endtask

  task automatic tColdOk();
    activate();
    sendAtr(AMIN);
    chkPin("R4", "ready at lowest valid count", P_RDY, 1);
    chkPin("R4", "window closed", P_WIN, 0);
  endtask

  task automatic tWarm();
    int n;
    warmReq = 1'b1;
    @(negedge clk);
    warmReq = 1'b0;
    chkPin("R9", "reset line low", P_RST, 0);
    chkPin("R9", "ready cleared", P_RDY, 0);
    chkPin("R9", "supply kept", P_VCC, 1);
    chkPin("R9", "clock kept", P_CLK, 1);
    waitFor(P_RST, 1'b1, 200, n);
    chk("R9", "warm hold length", n, HOLD);
    sendAtr(AMAX - 1);
    chkPin("R4", "ready at highest valid count", P_RDY, 1);
  endtask

  task automatic tEnd();
    endReq = 1'b1;
    @(negedge clk);
    endReq = 1'b0;
    chkPin("R10", "reset line low first", P_RST, 0);
    chkPin("R10", "clock still on", P_CLK, 1);
    deactCheck("R10");
  endtask

  task automatic tEarlyThenMute();
    int n;
    activate();
    sendAtr(AMIN - 1);
    chkPin("R5", "early answer rejected", P_RST, 0);
    chkPin("R5", "not ready after early answer", P_RDY, 0);
    chkPin("R7", "supply kept on retry", P_VCC, 1);
    chkPin("R7", "clock kept on retry", P_CLK, 1);
    chkPin("R7", "mute clear on retry", P_MUTE, 0);
    waitFor(P_RST, 1'b1, 200, n);
    chk("R7", "retry hold length", n, HOLD);
    waitFor(P_RST, 1'b0, AMAX + 10, n);
    chk("R6", "timeout after release", n, AMAX);
    chkPin("R8", "mute set after second failure", P_MUTE, 1);
    chkPin("R8", "clock still on at mute edge", P_CLK, 1);
    deactCheck("R8");
    chkPin("R8", "mute held while idle", P_MUTE, 1);
    activate();
    sendAtr(AMIN + 2);
    chkPin("R4", "ready after fresh session", P_RDY, 1);
    tEnd();
  endtask

  task automatic tTimeoutRetry();
    int n;
    activate();
    waitFor(P_RST, 1'b0, AMAX + 10, n);
    chk("R6", "first timeout length", n, AMAX);
    chkPin("R7", "supply kept on timeout retry", P_VCC, 1);
    chkPin("R7", "mute clear on first timeout", P_MUTE, 0);
    waitFor(P_RST, 1'b1, 200, n);
    chk("R7", "hold after timeout", n, HOLD);
    sendAtr(AMIN);
    chkPin("R7", "ready after retry answer", P_RDY, 1);
  endtask

  task automatic tRemoval();
    cardPresent = 1'b0;
    @(negedge clk);
    chkPin("R11", "reset line low on removal", P_RST, 0);
    chkPin("R11", "ready cleared on removal", P_RDY, 0);
    deactCheck("R11");
    cardPresent = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNoCard();
    tColdOk();
    tWarm();
    tEnd();
    tEarlyThenMute();
    tTimeoutRetry();
    tRemoval();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule